// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small accumulator machine with four instructions: load, add, store and branch-if-accumulator-zero. A hardwired step decoder would need its own logic for every timing step. This block instead reads its control pattern from a fixed table of sixteen 20-bit microwords. A 4-bit microword address register picks one entry. On every clock edge the picked entry is copied into a microword register, and the 14 control bits of that register drive the datapath control points directly. The datapath itself is outside this block.

Every microword names the microword that follows it. The decode microword works differently: it takes its successor from a four-entry dispatch table indexed by the opcode. In the same step it ORs the accumulator-zero flag into bit 0 of the successor address. The execute routines of load, add and store all start at odd addresses, so the OR has no effect on them. The branch routine starts at an even address, so the OR splits it into a "not taken" microword and a "taken" microword. The last microword of every routine names address 0, which starts the next fetch.

Each microword is 20 bits wide, packed from bit 19 down to bit 0:
- 14 control bits,
- a dispatch flag,
- a 4-bit next address,
- a flag that ORs the zero flag into the next address.

Top module: `useq_ctrl`

## Requirements
- R1: While reset is high at a rising edge, all 14 control outputs go low on that edge. The first edge after reset is released loads fetch step T0. A reset in the middle of an instruction abandons that instruction.
- R2: Each instruction begins with four fetch steps. T0 asserts mar_load and pc_drive. T1 asserts pc_step and mem_rd. T2 asserts mdr_drive and ir_load. T3 asserts nothing.
- R3: The step after T3 is selected by the op_code value held during T3: 0 is load, 1 is add, 2 is store, 3 is branch. op_code has no effect in any other step.
- R4: Load executes three steps after fetch: ir_drive+mar_load, then mem_rd, then mdr_drive+acc_load.
- R5: Add executes four steps after fetch: ir_drive+mar_load, then mem_rd, then alu_add, then tmp_drive+acc_load.
- R6: Store executes three steps after fetch: ir_drive+mar_load, then acc_drive+mdr_load, then mem_wr.
- R7: Branch executes one step after fetch. That step asserts ir_drive+pc_load if acc_zero was high during T3, and asserts nothing otherwise. acc_zero has no effect on any other instruction or step.
- R8: After the last execute step of every instruction, the next step is fetch T0.
- R9: The control outputs, packed as a vector, use the order bit 13 acc_load, 12 acc_drive, 11 alu_add, 10 ir_load, 9 ir_drive, 8 mar_load, 7 mdr_load, 6 mdr_drive, 5 pc_load, 4 pc_drive, 3 pc_step, 2 mem_rd, 1 tmp_drive, 0 mem_wr. No more than two of them are high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 2 | Opcode field of the instruction register |
| acc_zero | input | 1 | High when the accumulator is zero |
| acc_load | output | 1 | Load accumulator from bus |
| acc_drive | output | 1 | Drive accumulator onto bus |
| alu_add | output | 1 | Add memory data to accumulator into temp |
| ir_load | output | 1 | Load instruction register |
| ir_drive | output | 1 | Drive instruction address field onto bus |
| mar_load | output | 1 | Load memory address register |
| mdr_load | output | 1 | Load memory data register from bus |
| mdr_drive | output | 1 | Drive memory data register onto bus |
| pc_load | output | 1 | Load program counter from bus |
| pc_drive | output | 1 | Drive program counter onto bus |
| pc_step | output | 1 | Increment program counter |
| mem_rd | output | 1 | Memory read |
| tmp_drive | output | 1 | Drive temp register onto bus |
| mem_wr | output | 1 | Memory write |

## Verification
Table dispatch and the zero-flag OR act in the same cycle, because the decode microword carries both flags. To exercise this, every opcode is run with acc_zero both low and high. On the cycle after dispatch, op_code and acc_zero are flipped, to show that they are sampled only at the decode step. The results are judged against the full expected control sequence of each instruction. The check confirms three things: load, add and store enter the same routine whatever the flag value; the branch step splits on the flag; and the next fetch follows straight after.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;

    localparam int ADDR_W = 4;
    localparam int WORDS  = 1 << ADDR_W;
    localparam int OP_W   = 2;
    localparam int CTL_W  = 14;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 2'd0,
        OP_ADD   = 2'd1,
        OP_STORE = 2'd2,
        OP_BRZ   = 2'd3
    } opcode_e;

    typedef logic [ADDR_W-1:0] uaddr_t;
    typedef logic [CTL_W-1:0]  ctl_t;

    // Control point positions inside the control field
    localparam int CB_WRITE    = 0;
    localparam int CB_TMP_OUT  = 1;
    localparam int CB_READ     = 2;
    localparam int CB_PC_INCR  = 3;
    localparam int CB_PC_OUT   = 4;
    localparam int CB_PC_IN    = 5;
    localparam int CB_MDR_OUT  = 6;
    localparam int CB_MDR_IN   = 7;
    localparam int CB_MAR_IN   = 8;
    localparam int CB_IR_OUT   = 9;
    localparam int CB_IR_IN    = 10;
    localparam int CB_ALU_ADD  = 11;
    localparam int CB_ACC_OUT  = 12;
    localparam int CB_ACC_IN   = 13;

    localparam ctl_t M_WRITE   = ctl_t'(1) << CB_WRITE;
    localparam ctl_t M_TMP_OUT = ctl_t'(1) << CB_TMP_OUT;
    localparam ctl_t M_READ    = ctl_t'(1) << CB_READ;
    localparam ctl_t M_PC_INCR = ctl_t'(1) << CB_PC_INCR;
    localparam ctl_t M_PC_OUT  = ctl_t'(1) << CB_PC_OUT;
    localparam ctl_t M_PC_IN   = ctl_t'(1) << CB_PC_IN;
    localparam ctl_t M_MDR_OUT = ctl_t'(1) << CB_MDR_OUT;
    localparam ctl_t M_MDR_IN  = ctl_t'(1) << CB_MDR_IN;
    localparam ctl_t M_MAR_IN  = ctl_t'(1) << CB_MAR_IN;
    localparam ctl_t M_IR_OUT  = ctl_t'(1) << CB_IR_OUT;
    localparam ctl_t M_IR_IN   = ctl_t'(1) << CB_IR_IN;
    localparam ctl_t M_ALU_ADD = ctl_t'(1) << CB_ALU_ADD;
    localparam ctl_t M_ACC_OUT = ctl_t'(1) << CB_ACC_OUT;
    localparam ctl_t M_ACC_IN  = ctl_t'(1) << CB_ACC_IN;

    // Microword: control field, dispatch flag, successor, zero-OR flag
    typedef struct packed {
        ctl_t   ctl;
        logic   via_tbl;
        uaddr_t nxt;
        logic   or_zero;
    } uword_t;

    localparam int UWORD_W = $bits(uword_t);

    // Microprogram layout. Dispatch entries for load/add/store are odd so
    // the zero-OR applied at decode leaves them untouched; branch is even.
    localparam uaddr_t A_FETCH0  = uaddr_t'(0);
    localparam uaddr_t A_FETCH1  = uaddr_t'(1);
    localparam uaddr_t A_FETCH2  = uaddr_t'(2);
    localparam uaddr_t A_DECODE  = uaddr_t'(3);
    localparam uaddr_t A_BRZ_NO  = uaddr_t'(4);
    localparam uaddr_t A_BRZ_YES = uaddr_t'(5);
    localparam uaddr_t A_LD_RD   = uaddr_t'(6);
    localparam uaddr_t A_LD_ADR  = uaddr_t'(7);
    localparam uaddr_t A_LD_WB   = uaddr_t'(8);
    localparam uaddr_t A_AD_ADR  = uaddr_t'(9);
    localparam uaddr_t A_AD_RD   = uaddr_t'(10);
    localparam uaddr_t A_ST_ADR  = uaddr_t'(11);
    localparam uaddr_t A_AD_SUM  = uaddr_t'(12);
    localparam uaddr_t A_ST_MDR  = uaddr_t'(13);
    localparam uaddr_t A_AD_WB   = uaddr_t'(14);
    localparam uaddr_t A_ST_WR   = uaddr_t'(15);

    function automatic uword_t uw(ctl_t c, logic v, uaddr_t n, logic o);
        uword_t w;
        w.ctl     = c;
        w.via_tbl = v;
        w.nxt     = n;
        w.or_zero = o;
        return w;
    endfunction

    function automatic uword_t rom_word(uaddr_t a);
        uword_t w;
        case (a)
            A_FETCH0:  w = uw(M_MAR_IN | M_PC_OUT,  1'b0, A_FETCH1, 1'b0);
            A_FETCH1:  w = uw(M_PC_INCR | M_READ,   1'b0, A_FETCH2, 1'b0);
            A_FETCH2:  w = uw(M_MDR_OUT | M_IR_IN,  1'b0, A_DECODE, 1'b0);
            A_DECODE:  w = uw('0,                   1'b1, A_FETCH0, 1'b1);
            A_BRZ_NO:  w = uw('0,                   1'b0, A_FETCH0, 1'b0);
            A_BRZ_YES: w = uw(M_IR_OUT | M_PC_IN,   1'b0, A_FETCH0, 1'b0);
            A_LD_ADR:  w = uw(M_IR_OUT | M_MAR_IN,  1'b0, A_LD_RD,  1'b0);
            A_LD_RD:   w = uw(M_READ,               1'b0, A_LD_WB,  1'b0);
            A_LD_WB:   w = uw(M_MDR_OUT | M_ACC_IN, 1'b0, A_FETCH0, 1'b0);
            A_AD_ADR:  w = uw(M_IR_OUT | M_MAR_IN,  1'b0, A_AD_RD,  1'b0);
            A_AD_RD:   w = uw(M_READ,               1'b0, A_AD_SUM, 1'b0);
            A_AD_SUM:  w = uw(M_ALU_ADD,            1'b0, A_AD_WB,  1'b0);
            A_AD_WB:   w = uw(M_TMP_OUT | M_ACC_IN, 1'b0, A_FETCH0, 1'b0);
            A_ST_ADR:  w = uw(M_IR_OUT | M_MAR_IN,  1'b0, A_ST_MDR, 1'b0);
            A_ST_MDR:  w = uw(M_ACC_OUT | M_MDR_IN, 1'b0, A_ST_WR,  1'b0);
            A_ST_WR:   w = uw(M_WRITE,              1'b0, A_FETCH0, 1'b0);
            default:   w = '0;
        endcase
        return w;
    endfunction

    function automatic uaddr_t dispatch_entry(opcode_e op);
        uaddr_t a;
        case (op)
            OP_LOAD:  a = A_LD_ADR;
            OP_ADD:   a = A_AD_ADR;
            OP_STORE: a = A_ST_ADR;
            default:  a = A_BRZ_NO;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/useq_rom.sv
`timescale 1ns/1ps
module useq_rom
    import useq_pkg::*;
(
    input  uaddr_t addr,
    output uword_t word
);
    uword_t table_w [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_cell
        assign table_w[i] = rom_word(uaddr_t'(i));
    end

    assign word = table_w[addr];
endmodule

// File: rtl/useq_next.sv
`timescale 1ns/1ps
module useq_next
    import useq_pkg::*;
(
    input  uword_t              cur,
    input  logic [OP_W-1:0]     op_code,
    input  logic                acc_zero,
    output uaddr_t              nxt_addr
);
    uaddr_t base;
    uaddr_t zero_or;

    always_comb begin
        base    = cur.via_tbl ? dispatch_entry(opcode_e'(op_code)) : cur.nxt;
        zero_or = uaddr_t'(cur.or_zero & acc_zero);
        nxt_addr = base | zero_or;
    end
endmodule

// File: rtl/useq_regs.sv
`timescale 1ns/1ps
module useq_regs
    import useq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  uaddr_t addr_in,
    input  uword_t word_in,
    output uaddr_t addr_q,
    output uword_t word_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= A_FETCH0;
            word_q <= '0;
        end else begin
            addr_q <= addr_in;
            word_q <= word_in;
        end
    end
endmodule

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
module useq_ctrl
    import useq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  op_code,
    input  logic        acc_zero,
    output logic        acc_load,
    output logic        acc_drive,
    output logic        alu_add,
    output logic        ir_load,
    output logic        ir_drive,
    output logic        mar_load,
    output logic        mdr_load,
    output logic        mdr_drive,
    output logic        pc_load,
    output logic        pc_drive,
    output logic        pc_step,
    output logic        mem_rd,
    output logic        tmp_drive,
    output logic        mem_wr
);
    uaddr_t csar_q;
    uaddr_t next_addr;
    uword_t csir_q;
    uword_t rom_out;
    ctl_t   ctl_bus;

    useq_next u_next (
        .cur      (csir_q),
        .op_code  (op_code),
        .acc_zero (acc_zero),
        .nxt_addr (next_addr)
    );

    useq_rom u_rom (
        .addr (next_addr),
        .word (rom_out)
    );

    useq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr_in (next_addr),
        .word_in (rom_out),
        .addr_q  (csar_q),
        .word_q  (csir_q)
    );

    assign ctl_bus   = csir_q.ctl;
    assign acc_load  = ctl_bus[CB_ACC_IN];
    assign acc_drive = ctl_bus[CB_ACC_OUT];
    assign alu_add   = ctl_bus[CB_ALU_ADD];
    assign ir_load   = ctl_bus[CB_IR_IN];
    assign ir_drive  = ctl_bus[CB_IR_OUT];
    assign mar_load  = ctl_bus[CB_MAR_IN];
    assign mdr_load  = ctl_bus[CB_MDR_IN];
    assign mdr_drive = ctl_bus[CB_MDR_OUT];
    assign pc_load   = ctl_bus[CB_PC_IN];
    assign pc_drive  = ctl_bus[CB_PC_OUT];
    assign pc_step   = ctl_bus[CB_PC_INCR];
    assign mem_rd    = ctl_bus[CB_READ];
    assign tmp_drive = ctl_bus[CB_TMP_OUT];
    assign mem_wr    = ctl_bus[CB_WRITE];
endmodule

// File: rtl/useq_ctrl_chk.sv
`timescale 1ns/1ps
module useq_ctrl_chk
    import useq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] op_code,
    input logic       acc_zero,
    input uaddr_t     cs_addr,
    input ctl_t       ctl
);
    localparam ctl_t T0 = M_MAR_IN | M_PC_OUT;

    a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
        (ctl == T0) |=> (ctl == (M_PC_INCR | M_READ)));

    a_r2_decode_idle: assert property (@(posedge clk) disable iff (rst)
        (ctl == (M_MDR_OUT | M_IR_IN)) |=> (ctl == '0));

    a_r3_dispatch_add: assert property (@(posedge clk) disable iff (rst)
        (cs_addr == A_DECODE && op_code == OP_ADD) |=> (ctl == (M_IR_OUT | M_MAR_IN)));

    a_r5_sum_before_wb: assert property (@(posedge clk) disable iff (rst)
        ctl[CB_TMP_OUT] |-> $past(ctl[CB_ALU_ADD]));

    a_r6_write_after_mdr: assert property (@(posedge clk) disable iff (rst)
        ctl[CB_WRITE] |-> $past(ctl[CB_MDR_IN]));

    a_r7_brz_taken: assert property (@(posedge clk) disable iff (rst)
        (cs_addr == A_DECODE && op_code == OP_BRZ && acc_zero) |=> (ctl == (M_IR_OUT | M_PC_IN)));

    a_r7_brz_skip: assert property (@(posedge clk) disable iff (rst)
        (cs_addr == A_DECODE && op_code == OP_BRZ && !acc_zero) |=> (ctl == '0));

    a_r8_return: assert property (@(posedge clk) disable iff (rst)
        (ctl[CB_ACC_IN] || ctl[CB_WRITE] || ctl[CB_PC_IN]) |=> (ctl == T0));

    a_r9_at_most_two: assert property (@(posedge clk) disable iff (rst)
        $countones(ctl) <= 2);
endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_code  (op_code),
    .acc_zero (acc_zero),
    .cs_addr  (csar_q),
    .ctl      (ctl_bus)
);

// File: tb/useq_ctrl_tb_top.sv
`timescale 1ns/1ps
module useq_ctrl_tb_top;
    // Bit positions per R9
    localparam logic [13:0] E_ACC_IN  = 14'h1 << 13;
    localparam logic [13:0] E_ACC_OUT = 14'h1 << 12;
    localparam logic [13:0] E_ADD     = 14'h1 << 11;
    localparam logic [13:0] E_IR_IN   = 14'h1 << 10;
    localparam logic [13:0] E_IR_OUT  = 14'h1 << 9;
    localparam logic [13:0] E_MAR_IN  = 14'h1 << 8;
    localparam logic [13:0] E_MDR_IN  = 14'h1 << 7;
    localparam logic [13:0] E_MDR_OUT = 14'h1 << 6;
    localparam logic [13:0] E_PC_IN   = 14'h1 << 5;
    localparam logic [13:0] E_PC_OUT  = 14'h1 << 4;
    localparam logic [13:0] E_PC_INC  = 14'h1 << 3;
    localparam logic [13:0] E_READ    = 14'h1 << 2;
    localparam logic [13:0] E_TMP_OUT = 14'h1 << 1;
    localparam logic [13:0] E_WRITE   = 14'h1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] op_code = 2'd0;
    logic acc_zero = 1'b0;
    logic acc_load, acc_drive, alu_add, ir_load, ir_drive, mar_load, mdr_load;
    logic mdr_drive, pc_load, pc_drive, pc_step, mem_rd, tmp_drive, mem_wr;

    int n_cmp = 0;
    int n_bad = 0;
    logic rst_seen = 1'b0;
    logic [13:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    useq_ctrl dut_i (
        .clk(clk), .rst(rst), .op_code(op_code), .acc_zero(acc_zero),
        .acc_load(acc_load), .acc_drive(acc_drive), .alu_add(alu_add),
        .ir_load(ir_load), .ir_drive(ir_drive), .mar_load(mar_load),
        .mdr_load(mdr_load), .mdr_drive(mdr_drive), .pc_load(pc_load),
        .pc_drive(pc_drive), .pc_step(pc_step), .mem_rd(mem_rd),
        .tmp_drive(tmp_drive), .mem_wr(mem_wr)
    );

    wire [13:0] act = {acc_load, acc_drive, alu_add, ir_load, ir_drive, mar_load,
                       mdr_load, mdr_drive, pc_load, pc_drive, pc_step, mem_rd,
                       tmp_drive, mem_wr};

    always @(posedge clk) rst_seen <= rst;

    task automatic compare(logic [13:0] a, logic [13:0] e, string r);
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: controls actual %b expected %b", r, a, e);
        end
    endtask

    // Monitor: pops expected items in order and compares
    always @(negedge clk) begin
        if (rst_seen) begin
            compare(act, 14'h0, "R1");
        end else if (exp_q.size() > 0) begin
            logic [13:0] e;
            string r;
            e = exp_q.pop_front();
            r = tag_q.pop_front();
            compare(act, e, r);
            n_cmp++;
            if ($countones(act) > 2) begin
                n_bad++;
                $display("FAIL R9: actual %0d controls high, expected at most 2", $countones(act));
            end
        end
    end

    task automatic push(logic [13:0] v, string r);
        exp_q.push_back(v);
        tag_q.push_back(r);
    endtask

    task automatic push_fetch();
        push(E_MAR_IN | E_PC_OUT, "R2 T0 (R8 return)");
        push(E_PC_INC | E_READ,   "R2 T1");
        push(E_MDR_OUT | E_IR_IN, "R2 T2");
        push(14'h0,               "R2 T3");
    endtask

    // Driver: one instruction; scramble flips op_code/acc_zero after dispatch
    task automatic run_instr(logic [1:0] op, logic z, logic scramble);
        int len;
        op_code  = op;
        acc_zero = z;
        push_fetch();
        case (op)
            2'd0: begin
                push(E_IR_OUT | E_MAR_IN, "R4/R3 load addr");
                push(E_READ,              "R4 load read");
                push(E_MDR_OUT | E_ACC_IN,"R4 load wb");
                len = 7;
            end
            2'd1: begin
                push(E_IR_OUT | E_MAR_IN, "R5/R3 add addr");
                push(E_READ,              "R5 add read");
                push(E_ADD,               "R5 add sum");
                push(E_TMP_OUT | E_ACC_IN,"R5 add wb");
                len = 8;
            end
            2'd2: begin
                push(E_IR_OUT | E_MAR_IN, "R6/R3 store addr");
                push(E_ACC_OUT | E_MDR_IN,"R6 store mdr");
                push(E_WRITE,             "R6 store write");
                len = 7;
            end
            default: begin
                push(z ? (E_IR_OUT | E_PC_IN) : 14'h0, "R7/R3 branch");
                len = 5;
            end
        endcase
        repeat (5) @(negedge clk);
        if (scramble) begin
            op_code  = ~op;
            acc_zero = ~z;
        end
        repeat (len - 5) @(negedge clk);
    endtask

    task automatic mid_reset();
        op_code = 2'd1;
        push(E_MAR_IN | E_PC_OUT, "R2 T0");
        push(E_PC_INC | E_READ,   "R2 T1");
        repeat (2) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run_instr(2'd0, 1'b0, 1'b0);
        run_instr(2'd1, 1'b1, 1'b1);
        run_instr(2'd2, 1'b0, 1'b0);
        run_instr(2'd3, 1'b1, 1'b0);
        run_instr(2'd3, 1'b0, 1'b0);
        run_instr(2'd0, 1'b1, 1'b1);
        mid_reset();
        run_instr(2'd3, 1'b1, 1'b0);
        for (int o = 0; o < 4; o++) begin
            for (int zz = 0; zz < 2; zz++) begin
                run_instr(2'(o), zz[0], 1'b1);
            end
        end
        run_instr(2'd2, 1'b1, 1'b1);
        @(negedge clk);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8: %0d expected steps left, expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R8: watchdog expired, actual hung run, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule